// File: doc/BRIEF.md
# Boot-Remap Address Decoder

This block decodes the two address streams of an 8051-class processor that loads its own firmware into on-chip RAM before running it. The code-fetch stream and the external-data stream, each with its strobes, are turned into chip selects, write enables and local offsets for four targets: a 6 KB boot ROM, an 8 KB program RAM, a 512-byte buffer RAM and a 128-byte register window. The block also returns read data for each stream. When an address falls in no region, the read data is all ones.

A control register sits at one address inside the register window. It holds two bits, and both are cleared by power-up reset or by a synchronous function reset. The first bit is the remap bit. While it is 0 (load layout), instructions come from the boot ROM at the bottom of code space, and the program RAM is open for reads and writes through data space. Software can set the remap bit but cannot clear it. Once it is 1 (run layout), the program RAM is the bottom of code space and can no longer be written. The boot ROM is then reachable only through its copy in the upper half of code space. The second bit is the attach bit. It stays 0 until firmware sets it, and it holds the device off the bus until the load is finished.

The program RAM has a single port. In the load layout its address comes from the data stream. In the run layout its address comes from the code stream.

Top module: `bootmap_decoder`

## Requirements
- R1: After rst_n is released, remap_o and attach_o are 0, and a data read of the control address (0xFFC0) returns 0x00.
- R2: With remap 0, a code read of 0x0000–0x17FF asserts rom_cs with rom_addr equal to the address. code_rdata then equals rom_q. Code addresses 0x1800–0x1FFF select nothing.
- R3: In both layouts, a code read of 0x8000–0x97FF asserts rom_cs with rom_addr equal to the address minus 0x8000, and returns rom_q.
- R4: With remap 0, a data access to 0x0000–0x1FFF asserts pram_cs with pram_addr equal to the address. A write also asserts pram_we. A read returns pram_q on data_rdata.
- R5: With remap 1, a code read of 0x0000–0x1FFF asserts pram_cs with pram_addr equal to the address and returns pram_q. rom_cs stays low.
- R6: With remap 1, a data write to 0x0000–0x1FFF asserts neither pram_cs nor pram_we. The RAM contents seen later through code reads are unchanged, and a data read there returns 0xFF.
- R7: In both layouts, data accesses to 0xFD80–0xFF7F assert buf_cs with buf_addr equal to the address minus 0xFD80. buf_we is asserted for writes, and reads return buf_q.
- R8: Data accesses to 0xFF80–0xFFFF other than 0xFFC0 assert mmr_cs with mmr_addr equal to the address minus 0xFF80. mmr_we is asserted for writes, and reads return mmr_q.
- R9: A data write to 0xFFC0 sets remap when bit 0 of the write data is 1. A 0 in bit 0 leaves remap unchanged. attach takes the value of bit 1 of the write data. A read of 0xFFC0 returns remap in bit 0 and attach in bit 1, with all other bits 0, and asserts no chip select.
- R10: remap returns to 0 only through rst_n low or through func_rst high at a clock edge. func_rst clears attach as well.
- R11: Code or data addresses outside every region assert no chip select and read as 0xFF.
- R12: Chip selects are asserted only while a matching strobe is high. At most one of pram_we, buf_cs and mmr_cs is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| func_rst | input | 1 | Synchronous function reset, clears both control bits |
| code_addr | input | 16 | Code-fetch address |
| code_rd | input | 1 | Code-fetch strobe |
| data_addr | input | 16 | External-data address |
| data_rd | input | 1 | Data read strobe |
| data_wr | input | 1 | Data write strobe |
| data_wdata | input | 8 | Data write value |
| rom_q | input | 8 | Boot ROM read data |
| pram_q | input | 8 | Program RAM read data |
| buf_q | input | 8 | Buffer RAM read data |
| mmr_q | input | 8 | Register window read data |
| rom_cs | output | 1 | Boot ROM select |
| rom_addr | output | 13 | Boot ROM offset |
| pram_cs | output | 1 | Program RAM select |
| pram_we | output | 1 | Program RAM write enable |
| pram_addr | output | 13 | Program RAM offset |
| buf_cs | output | 1 | Buffer RAM select |
| buf_we | output | 1 | Buffer RAM write enable |
| buf_addr | output | 9 | Buffer RAM offset |
| mmr_cs | output | 1 | Register window select |
| mmr_we | output | 1 | Register window write enable |
| mmr_addr | output | 7 | Register window offset |
| code_rdata | output | 8 | Code read data |
| data_rdata | output | 8 | Data read data |
| remap_o | output | 1 | Layout bit, 1 for run layout |
| attach_o | output | 1 | Bus attach bit |

## Verification
The assertions assume that data_rd and data_wr are never high in the same cycle. They also assume that addresses, strobes and write data are steady from one falling edge to the next, so the combinational selects settle before each rising edge. The stimulus changes inputs only on falling edges. It raises at most one data strobe per access. It lowers every strobe once a control write has been clocked in, so each register write happens exactly once. func_rst is driven only with the data strobes low.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Address region a stream decodes to
    typedef enum logic [2:0] {
        RG_NONE,
        RG_ROM,
        RG_PRAM,
        RG_BUF,
        RG_MMR,
        RG_CTRL
    } region_e;

    // The two registered control bits
    typedef struct packed {
        logic attach;
        logic remap;
    } ctrl_t;

endpackage

// File: rtl/bootmap_code_dec.sv
module bootmap_code_dec
    import bootmap_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int ROM_BYTES   = 6144,
    parameter int PRAM_BYTES  = 8192,
    parameter int ROM_MIRROR  = 32768,
    parameter int ROM_AW      = $clog2(ROM_BYTES),
    parameter int PRAM_AW     = $clog2(PRAM_BYTES)
) (
    input  logic [ADDR_W-1:0]  code_addr,
    input  logic               code_rd,
    input  logic               remap,
    output region_e            region,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic [PRAM_AW-1:0] pram_addr
);

    logic [ADDR_W-1:0] mir_off;
    logic              hit_mirror;
    logic              hit_low_rom;
    logic              hit_low_pram;

    assign mir_off      = code_addr - ADDR_W'(ROM_MIRROR);
    assign hit_mirror   = mir_off   < ADDR_W'(ROM_BYTES);
    assign hit_low_rom  = code_addr < ADDR_W'(ROM_BYTES);
    assign hit_low_pram = code_addr < ADDR_W'(PRAM_BYTES);
    assign pram_addr    = code_addr[PRAM_AW-1:0];

    always_comb begin
        region   = RG_NONE;
        rom_addr = '0;
        if (code_rd) begin
            if (hit_mirror) begin
                region   = RG_ROM;
                rom_addr = mir_off[ROM_AW-1:0];
            end else if (remap && hit_low_pram) begin
                region   = RG_PRAM;
            end else if (!remap && hit_low_rom) begin
                region   = RG_ROM;
                rom_addr = code_addr[ROM_AW-1:0];
            end
        end
    end

endmodule

// File: rtl/bootmap_data_dec.sv
module bootmap_data_dec
    import bootmap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PRAM_BYTES = 8192,
    parameter int BUF_BASE   = 64896,
    parameter int BUF_BYTES  = 512,
    parameter int MMR_BASE   = 65408,
    parameter int MMR_BYTES  = 128,
    parameter int CTRL_ADDR  = 65472,
    parameter int PRAM_AW    = $clog2(PRAM_BYTES),
    parameter int BUF_AW     = $clog2(BUF_BYTES),
    parameter int MMR_AW     = $clog2(MMR_BYTES)
) (
    input  logic [ADDR_W-1:0]  data_addr,
    input  logic               data_rd,
    input  logic               data_wr,
    input  logic               remap,
    output region_e            region,
    output logic [PRAM_AW-1:0] pram_addr,
    output logic [BUF_AW-1:0]  buf_addr,
    output logic [MMR_AW-1:0]  mmr_addr
);

    logic [ADDR_W-1:0] buf_off;
    logic [ADDR_W-1:0] mmr_off;
    logic              strobe;

    assign strobe    = data_rd | data_wr;
    assign buf_off   = data_addr - ADDR_W'(BUF_BASE);
    assign mmr_off   = data_addr - ADDR_W'(MMR_BASE);
    assign pram_addr = data_addr[PRAM_AW-1:0];
    assign buf_addr  = buf_off[BUF_AW-1:0];
    assign mmr_addr  = mmr_off[MMR_AW-1:0];

    always_comb begin
        region = RG_NONE;
        if (strobe) begin
            if (data_addr == ADDR_W'(CTRL_ADDR)) begin
                region = RG_CTRL;
            end else if (mmr_off < ADDR_W'(MMR_BYTES)) begin
                region = RG_MMR;
            end else if (buf_off < ADDR_W'(BUF_BYTES)) begin
                region = RG_BUF;
            end else if (!remap && data_addr < ADDR_W'(PRAM_BYTES)) begin
                region = RG_PRAM;
            end
        end
    end

endmodule

// File: rtl/bootmap_ctrl_reg.sv
module bootmap_ctrl_reg
    import bootmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic func_rst,
    input  logic wr_en,
    input  logic wr_remap,
    input  logic wr_attach,
    output logic remap,
    output logic attach
);

    ctrl_t ctrl_d;
    ctrl_t ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (func_rst) begin
            ctrl_d = '0;
        end else if (wr_en) begin
            // remap can only be set from software
            ctrl_d.remap  = ctrl_q.remap | wr_remap;
            ctrl_d.attach = wr_attach;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign remap  = ctrl_q.remap;
    assign attach = ctrl_q.attach;

endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int ROM_BYTES  = 6144,
    parameter int PRAM_BYTES = 8192,
    parameter int ROM_MIRROR = 32768,
    parameter int BUF_BASE   = 64896,
    parameter int BUF_BYTES  = 512,
    parameter int MMR_BASE   = 65408,
    parameter int MMR_BYTES  = 128,
    parameter int CTRL_ADDR  = 65472,
    parameter int REMAP_BIT  = 0,
    parameter int ATTACH_BIT = 1,
    parameter int ROM_AW     = $clog2(ROM_BYTES),
    parameter int PRAM_AW    = $clog2(PRAM_BYTES),
    parameter int BUF_AW     = $clog2(BUF_BYTES),
    parameter int MMR_AW     = $clog2(MMR_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               func_rst,
    input  logic [ADDR_W-1:0]  code_addr,
    input  logic               code_rd,
    input  logic [ADDR_W-1:0]  data_addr,
    input  logic               data_rd,
    input  logic               data_wr,
    input  logic [DATA_W-1:0]  data_wdata,
    input  logic [DATA_W-1:0]  rom_q,
    input  logic [DATA_W-1:0]  pram_q,
    input  logic [DATA_W-1:0]  buf_q,
    input  logic [DATA_W-1:0]  mmr_q,
    output logic               rom_cs,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               pram_cs,
    output logic               pram_we,
    output logic [PRAM_AW-1:0] pram_addr,
    output logic               buf_cs,
    output logic               buf_we,
    output logic [BUF_AW-1:0]  buf_addr,
    output logic               mmr_cs,
    output logic               mmr_we,
    output logic [MMR_AW-1:0]  mmr_addr,
    output logic [DATA_W-1:0]  code_rdata,
    output logic [DATA_W-1:0]  data_rdata,
    output logic               remap_o,
    output logic               attach_o
);

    region_e            code_rg;
    region_e            data_rg;
    logic [PRAM_AW-1:0] code_pram_addr;
    logic [PRAM_AW-1:0] data_pram_addr;
    logic               remap;
    logic               attach;
    logic               ctrl_wr;
    logic [DATA_W-1:0]  ctrl_rd;

    bootmap_code_dec #(
        .ADDR_W     (ADDR_W),
        .ROM_BYTES  (ROM_BYTES),
        .PRAM_BYTES (PRAM_BYTES),
        .ROM_MIRROR (ROM_MIRROR),
        .ROM_AW     (ROM_AW),
        .PRAM_AW    (PRAM_AW)
    ) u_code_dec (
        .code_addr (code_addr),
        .code_rd   (code_rd),
        .remap     (remap),
        .region    (code_rg),
        .rom_addr  (rom_addr),
        .pram_addr (code_pram_addr)
    );

    bootmap_data_dec #(
        .ADDR_W     (ADDR_W),
        .PRAM_BYTES (PRAM_BYTES),
        .BUF_BASE   (BUF_BASE),
        .BUF_BYTES  (BUF_BYTES),
        .MMR_BASE   (MMR_BASE),
        .MMR_BYTES  (MMR_BYTES),
        .CTRL_ADDR  (CTRL_ADDR),
        .PRAM_AW    (PRAM_AW),
        .BUF_AW     (BUF_AW),
        .MMR_AW     (MMR_AW)
    ) u_data_dec (
        .data_addr (data_addr),
        .data_rd   (data_rd),
        .data_wr   (data_wr),
        .remap     (remap),
        .region    (data_rg),
        .pram_addr (data_pram_addr),
        .buf_addr  (buf_addr),
        .mmr_addr  (mmr_addr)
    );

    assign ctrl_wr = data_wr && (data_rg == RG_CTRL);

    bootmap_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .func_rst  (func_rst),
        .wr_en     (ctrl_wr),
        .wr_remap  (data_wdata[REMAP_BIT]),
        .wr_attach (data_wdata[ATTACH_BIT]),
        .remap     (remap),
        .attach    (attach)
    );

    // Chip selects and write enables
    assign rom_cs    = (code_rg == RG_ROM);
    assign pram_cs   = (code_rg == RG_PRAM) || (data_rg == RG_PRAM);
    assign pram_we   = (data_rg == RG_PRAM) && data_wr;
    assign pram_addr = remap ? code_pram_addr : data_pram_addr;
    assign buf_cs    = (data_rg == RG_BUF);
    assign buf_we    = buf_cs && data_wr;
    assign mmr_cs    = (data_rg == RG_MMR);
    assign mmr_we    = mmr_cs && data_wr;
    assign remap_o   = remap;
    assign attach_o  = attach;

    always_comb begin
        ctrl_rd             = '0;
        ctrl_rd[REMAP_BIT]  = remap;
        ctrl_rd[ATTACH_BIT] = attach;
    end

    // Read-data steering, unmapped reads as all ones
    always_comb begin
        unique case (code_rg)
            RG_ROM:  code_rdata = rom_q;
            RG_PRAM: code_rdata = pram_q;
            default: code_rdata = '1;
        endcase
    end

    always_comb begin
        unique case (data_rg)
            RG_PRAM: data_rdata = pram_q;
            RG_BUF:  data_rdata = buf_q;
            RG_MMR:  data_rdata = mmr_q;
            RG_CTRL: data_rdata = ctrl_rd;
            default: data_rdata = '1;
        endcase
    end

endmodule

// File: rtl/bootmap_decoder_chk.sv
module bootmap_decoder_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 65472
) (
    input logic              clk,
    input logic              rst_n,
    input logic              func_rst,
    input logic              code_rd,
    input logic [ADDR_W-1:0] data_addr,
    input logic              data_rd,
    input logic              data_wr,
    input logic              rom_cs,
    input logic              pram_cs,
    input logic              pram_we,
    input logic              buf_cs,
    input logic              mmr_cs,
    input logic [DATA_W-1:0] data_rdata,
    input logic              remap_o,
    input logic              attach_o
);

    AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_o && !func_rst) |=> remap_o); // R10

    AST_FRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        func_rst |=> (!remap_o && !attach_o)); // R10

    AST_NO_WRITE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        remap_o |-> !pram_we); // R6

    AST_DATA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pram_we, buf_cs, mmr_cs})); // R12

    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_rd && !data_rd && !data_wr) |-> !(rom_cs || pram_cs || buf_cs || mmr_cs)); // R12

    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !buf_cs && !mmr_cs && (remap_o || !pram_cs)
         && data_addr != ADDR_W'(CTRL_ADDR)) |-> (data_rdata == '1)); // R11

endmodule

bind bootmap_decoder bootmap_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .func_rst   (func_rst),
    .code_rd    (code_rd),
    .data_addr  (data_addr),
    .data_rd    (data_rd),
    .data_wr    (data_wr),
    .rom_cs     (rom_cs),
    .pram_cs    (pram_cs),
    .pram_we    (pram_we),
    .buf_cs     (buf_cs),
    .mmr_cs     (mmr_cs),
    .data_rdata (data_rdata),
    .remap_o    (remap_o),
    .attach_o   (attach_o)
);

// File: tb/bootmap_decoder_tb.sv
module bootmap_decoder_tb;

    localparam logic [15:0] CTRL = 16'hFFC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        func_rst = 1'b0;
    logic [15:0] code_addr = '0;
    logic        code_rd = 1'b0;
    logic [15:0] data_addr = '0;
    logic        data_rd = 1'b0;
    logic        data_wr = 1'b0;
    logic [7:0]  data_wdata = '0;
    logic [7:0]  rom_q, pram_q, buf_q, mmr_q;
    logic        rom_cs, pram_cs, pram_we, buf_cs, buf_we, mmr_cs, mmr_we;
    logic [12:0] rom_addr, pram_addr;
    logic [8:0]  buf_addr;
    logic [6:0]  mmr_addr;
    logic [7:0]  code_rdata, data_rdata;
    logic        remap_o, attach_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // Behavioural memories
    logic [7:0] pram_mem [64];
    assign rom_q  = rom_addr[7:0] ^ 8'hA5;
    assign buf_q  = buf_addr[7:0] ^ 8'h3C;
    assign mmr_q  = {1'b0, mmr_addr} ^ 8'h11;
    assign pram_q = pram_mem[pram_addr[5:0]];
    always @(posedge clk) if (pram_we) pram_mem[pram_addr[5:0]] <= data_wdata;

    bootmap_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .func_rst(func_rst),
        .code_addr(code_addr), .code_rd(code_rd),
        .data_addr(data_addr), .data_rd(data_rd), .data_wr(data_wr),
        .data_wdata(data_wdata),
        .rom_q(rom_q), .pram_q(pram_q), .buf_q(buf_q), .mmr_q(mmr_q),
        .rom_cs(rom_cs), .rom_addr(rom_addr),
        .pram_cs(pram_cs), .pram_we(pram_we), .pram_addr(pram_addr),
        .buf_cs(buf_cs), .buf_we(buf_we), .buf_addr(buf_addr),
        .mmr_cs(mmr_cs), .mmr_we(mmr_we), .mmr_addr(mmr_addr),
        .code_rdata(code_rdata), .data_rdata(data_rdata),
        .remap_o(remap_o), .attach_o(attach_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        code_rd = 0; data_rd = 0; data_wr = 0;
    endtask

    task automatic code_read(input logic [15:0] a);
        @(negedge clk);
        code_addr = a; code_rd = 1; data_rd = 0; data_wr = 0;
        #2;
    endtask

    task automatic data_read(input logic [15:0] a);
        @(negedge clk);
        data_addr = a; data_rd = 1; data_wr = 0; code_rd = 0;
        #2;
    endtask

    task automatic data_write(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        data_addr = a; data_wdata = v; data_wr = 1; data_rd = 0; code_rd = 0;
        #2;
    endtask

    task automatic t_reset();
        chk("R1 remap", remap_o, 0);
        chk("R1 attach", attach_o, 0);
        data_read(CTRL);
        chk("R1 ctrl read", data_rdata, 8'h00);
        idle();
    endtask

    task automatic t_boot_code();
        for (int i = 0; i < 3; i++) begin
            logic [15:0] a;
            a = (i == 0) ? 16'h0000 : (i == 1) ? 16'h0A13 : 16'h17FF;
            code_read(a);
            chk("R2 rom_cs", rom_cs, 1);
            chk("R2 rom_addr", rom_addr, a[12:0]);
            chk("R2 rdata", code_rdata, a[7:0] ^ 8'hA5);
        end
        code_read(16'h1800);
        chk("R2 gap no rom_cs", rom_cs, 0);
        chk("R2 gap rdata", code_rdata, 8'hFF);
        idle();
    endtask

    task automatic t_mirror(input string tag);
        code_read(16'h8000);
        chk({tag, " R3 mirror lo cs"}, rom_cs, 1);
        chk({tag, " R3 mirror lo addr"}, rom_addr, 0);
        code_read(16'h97FF);
        chk({tag, " R3 mirror hi addr"}, rom_addr, 13'h17FF);
        chk({tag, " R3 mirror rdata"}, code_rdata, 8'hFF ^ 8'hA5);
        code_read(16'h9800);
        chk({tag, " R3 past mirror"}, rom_cs, 0);
        idle();
    endtask

    task automatic t_boot_data();
        data_write(16'h0005, 8'h5A);
        chk("R4 pram_cs", pram_cs, 1);
        chk("R4 pram_we", pram_we, 1);
        chk("R4 pram_addr", pram_addr, 13'h0005);
        data_write(16'h1FC0, 8'hC3);
        chk("R4 top pram_we", pram_we, 1);
        data_read(16'h0005);
        chk("R4 read we low", pram_we, 0);
        chk("R4 readback", data_rdata, 8'h5A);
        data_read(16'h1FC0);
        chk("R4 readback top", data_rdata, 8'hC3);
        idle();
    endtask

    task automatic t_unmapped();
        code_read(16'h4000);
        chk("R11 code none", {rom_cs, pram_cs}, 0);
        chk("R11 code ff", code_rdata, 8'hFF);
        data_read(16'h2000);
        chk("R11 data none", {pram_cs, buf_cs, mmr_cs}, 0);
        chk("R11 data ff", data_rdata, 8'hFF);
        data_read(16'hFD7F);
        chk("R11 below buf", buf_cs, 0);
        idle();
    endtask

    task automatic t_buffer(input string tag);
        data_read(16'hFD80);
        chk({tag, " R7 buf_cs"}, buf_cs, 1);
        chk({tag, " R7 buf_addr"}, buf_addr, 0);
        chk({tag, " R7 rdata"}, data_rdata, 8'h3C);
        data_write(16'hFF7F, 8'h01);
        chk({tag, " R7 buf_we"}, buf_we, 1);
        chk({tag, " R7 buf_addr top"}, buf_addr, 9'h1FF);
        idle();
    endtask

    task automatic t_mmr();
        data_read(16'hFF80);
        chk("R8 mmr_cs", mmr_cs, 1);
        chk("R8 mmr_addr", mmr_addr, 0);
        chk("R8 rdata", data_rdata, 8'h11);
        data_write(16'hFFFF, 8'h00);
        chk("R8 mmr_we", mmr_we, 1);
        chk("R8 mmr_addr top", mmr_addr, 7'h7F);
        idle();
        data_read(CTRL);
        chk("R9 ctrl no mmr_cs", {mmr_cs, buf_cs, pram_cs}, 0);
        idle();
    endtask

    task automatic t_strobes();
        @(negedge clk);
        code_addr = 16'h0010; data_addr = 16'hFE00;
        code_rd = 0; data_rd = 0; data_wr = 0;
        #2;
        chk("R12 no strobe no cs", {rom_cs, pram_cs, buf_cs, mmr_cs}, 0);
    endtask

    task automatic t_ctrl();
        data_write(CTRL, 8'h00);
        idle(); #2;
        chk("R9 zero write keeps remap", remap_o, 0);
        data_write(CTRL, 8'h02);
        idle(); #2;
        chk("R9 attach set", attach_o, 1);
        chk("R9 remap still 0", remap_o, 0);
        data_write(CTRL, 8'h03);
        idle(); #2;
        chk("R9 remap set", remap_o, 1);
        data_read(CTRL);
        chk("R9 ctrl readback", data_rdata, 8'h03);
        idle();
    endtask

    task automatic t_run_layout();
        code_read(16'h0005);
        chk("R5 pram_cs", pram_cs, 1);
        chk("R5 no rom_cs", rom_cs, 0);
        chk("R5 pram_addr", pram_addr, 13'h0005);
        chk("R5 rdata", code_rdata, 8'h5A);
        code_read(16'h1FC0);
        chk("R5 top rdata", code_rdata, 8'hC3);
        code_read(16'h2000);
        chk("R11 run code gap", code_rdata, 8'hFF);
        idle();
    endtask

    task automatic t_blocked();
        data_write(16'h0005, 8'h99);
        chk("R6 no pram_we", pram_we, 0);
        chk("R6 no pram_cs", pram_cs, 0);
        idle();
        data_read(16'h0005);
        chk("R6 data read ff", data_rdata, 8'hFF);
        code_read(16'h0005);
        chk("R6 contents kept", code_rdata, 8'h5A);
        idle();
    endtask

    task automatic t_clear_paths();
        data_write(CTRL, 8'h00);
        idle(); #2;
        chk("R10 sw cannot clear", remap_o, 1);
        chk("R9 attach cleared by write", attach_o, 0);
        data_write(CTRL, 8'h02);
        idle(); #2;
        @(negedge clk); func_rst = 1;
        @(negedge clk); func_rst = 0; #2;
        chk("R10 func_rst remap", remap_o, 0);
        chk("R10 func_rst attach", attach_o, 0);
        code_read(16'h0100);
        chk("R10 boot layout back", rom_cs, 1);
        idle();
        data_write(CTRL, 8'h01);
        idle();
        @(negedge clk); rst_n = 0;
        #2;
        chk("R10 rst_n clears", remap_o, 0);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_boot_code();
        t_mirror("boot");
        t_boot_data();
        t_unmapped();
        t_buffer("boot");
        t_mmr();
        t_strobes();
        t_ctrl();
        t_run_layout();
        t_mirror("run");
        t_buffer("run");
        t_blocked();
        t_clear_paths();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule